// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. A single free-running 64-bit main counter is shared by a parameterised set of comparator channels. Each channel watches the counter and fires when the counter reaches the value in its comparator. A channel is either one-shot, which fires once and then waits for software to load a new value, or periodic, which adds a stored period to its comparator after every firing so that later expiries follow without software help. Software reprograms a channel by writing that channel's registers only. The shared counter is rewritten only to set its starting value, because a rewrite moves every channel at once.

Software reaches the block through a simple 32-bit register bus in a 1024-byte window. A write takes effect on the clock edge that samples `bus_wr`. Read data is registered and appears in the cycle after `bus_rd`. Each channel drives its own interrupt output, in level or edge form, and a route field steers that output onto one of several shared interrupt lines. The lines a channel may use are fixed by a capability mask.

Each channel contains a small sequencer that controls where a comparator commit goes. The sequencer has three states. It stays in `SEQ_DIRECT` until a configuration write sets both the periodic and value-set bits on a periodic-capable channel, which moves it to `SEQ_FIRST`. In `SEQ_FIRST`, a commit loads the first expiry into the comparator and moves the sequencer to `SEQ_PERIOD`. In `SEQ_PERIOD`, a commit loads the period register and returns the sequencer to `SEQ_DIRECT`. In `SEQ_DIRECT`, a commit loads the comparator and re-arms the channel.

Top module: `evt_timer`

## Requirements
- R1: After reset the following all read 0: the counter, the general configuration register, the status register, and every writable channel field. Every interrupt output is low. The capability low word at 0x000 reads as follows: bits [7:0] hold revision 0x01, bits [12:8] hold the channel count minus one, and bit 13 reads 1 to report a 64-bit counter. The capability high word at 0x004 holds the tick period in femtoseconds. Bit 4 of a channel's configuration register reads 1 when that channel can run periodic. The word at channel offset 0x4 reads the channel's route capability mask.
- R2: The counter is readable and writable as two halves: the low half at 0x0F0 and the high half at 0x0F4. It increments by one on each clock only while bit 0 of the general configuration register at 0x010 is 1, and it holds its value while that bit is 0. A write to either half takes priority over the increment.
- R3: The registers of channel i start at 0x100 + 0x20*i: configuration at +0x0, comparator low half at +0x8 and comparator high half at +0xC. A low-half write is only staged, and the write to the high half commits the full 64-bit value. A one-shot channel fires once when the counter equals its comparator, and fires again only after a new commit. If the match happens in the cycle where the counter reads C, the outputs change in the cycle where the counter reads C+1.
- R4: With configuration bit 1 clear (edge type), a firing produces a ch_irq pulse one clock long, and the status register is not touched.
- R5: With configuration bit 1 set (level type), a firing sets bit i of the status register at 0x020. Writing 1 to bit i clears it, writing 0 leaves it unchanged, and a level ch_irq stays high for as long as the status bit is set.
- R6: Writing a configuration word with bit 3 (periodic) and bit 6 (value-set) both set to a periodic-capable channel starts the load sequence: the next commit loads the first expiry, and the commit after that loads the period without changing the comparator. Bit 6 always reads 0.
- R7: A periodic channel adds its period to the comparator on the clock after each match and stays armed, so it fires at C, C+P, C+2P and so on.
- R8: On a channel without periodic capability, bits 3 and 6 are ignored: both read 0, every commit loads the comparator directly, and the channel behaves as one-shot.
- R9: With bit 8 (force 32-bit) set, only the low 32 bits of the counter and comparator are compared. A low-half comparator write then commits at once, with the upper half cleared.
- R10: Configuration bit 2 (interrupt enable) gates only ch_irq. A level channel still records its status bit while disabled, and enabling it later raises ch_irq.
- R11: Configuration bits [10:9] select the interrupt line that the channel drives. A value whose bit in the channel's capability mask is 0 is ignored and the old route is kept. irq_line[l] is the OR of the ch_irq outputs routed to line l.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ch_irq | output | NUM_CH | Per-channel interrupt |
| irq_line | output | NUM_LINES | Routed interrupt lines |

## Verification
The properties assume that the counter changes only through its own two bus addresses and that status bits clear only through a one-written to the status address. The bench keeps to both. The properties also assume the counter never wraps, and every scenario starts from reset with comparators a few dozen ticks ahead, so a wrap cannot occur. Writes are never issued in the cycle the bench samples an expiry, so a commit and a match never coincide.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int ADDR_W = 10;

    localparam logic [ADDR_W-1:0] A_CAP_LO = 10'h000;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 10'h004;
    localparam logic [ADDR_W-1:0] A_GEN    = 10'h010;
    localparam logic [ADDR_W-1:0] A_STS    = 10'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h0F4;

    // channel slots are 32 bytes wide starting at 0x100
    localparam int CH_SLOT_LSB = 5;
    localparam int CH_BASE_IDX = 8;

    localparam logic [1:0] R_CFG   = 2'd0;
    localparam logic [1:0] R_RCAP  = 2'd1;
    localparam logic [1:0] R_CMPLO = 2'd2;
    localparam logic [1:0] R_CMPHI = 2'd3;

    localparam int B_LEVEL = 1;
    localparam int B_IEN   = 2;
    localparam int B_PER   = 3;
    localparam int B_PCAP  = 4;
    localparam int B_VSET  = 6;
    localparam int B_F32   = 8;
    localparam int B_ROUTE = 9;

    localparam logic [7:0] CAP_REV = 8'h01;

    typedef enum logic [1:0] {
        SEQ_DIRECT = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_PERIOD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo) begin
            cnt[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt[CNT_W-1:DATA_W] <= wdata;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter bit                   PCAP      = 1'b1,
    parameter int                   NUM_LINES = 4,
    parameter logic [NUM_LINES-1:0] RCAP      = '1,
    localparam int                  RW        = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_en,
    input  logic              cfg_we,
    input  logic              cmp_lo_we,
    input  logic              cmp_hi_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [CNT_W-1:0]  cmp_rd,
    output logic              fire,
    output logic              is_level,
    output logic              irq_en,
    output logic [RW-1:0]     route
);
    seq_state_e seq_q, seq_d;

    logic              level_q, ien_q, per_q, f32_q, armed_q;
    logic [RW-1:0]     route_q;
    logic [CNT_W-1:0]  cmp_q, period_q;
    logic [DATA_W-1:0] stage_lo_q;

    logic              commit, match, vset_req;
    logic [CNT_W-1:0]  commit_val, next_cmp;
    logic [RW-1:0]     route_wr;

    assign commit     = cmp_hi_we | (cmp_lo_we & f32_q);
    assign commit_val = f32_q ? {{(CNT_W-DATA_W){1'b0}}, wdata} : {wdata, stage_lo_q};
    assign match      = cnt_en & armed_q &
                        (f32_q ? (cnt[DATA_W-1:0] == cmp_q[DATA_W-1:0]) : (cnt == cmp_q));
    assign vset_req   = cfg_we & PCAP & wdata[B_PER] & wdata[B_VSET];
    assign route_wr   = wdata[B_ROUTE +: RW];
    assign next_cmp   = f32_q ? {{(CNT_W-DATA_W){1'b0}}, cmp_q[DATA_W-1:0] + period_q[DATA_W-1:0]}
                              : cmp_q + period_q;

    // load-sequence state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_DIRECT;
        else        seq_q <= seq_d;
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_DIRECT: if (vset_req) seq_d = SEQ_FIRST;
            SEQ_FIRST:  if (commit)   seq_d = SEQ_PERIOD;
            SEQ_PERIOD: if (commit)   seq_d = SEQ_DIRECT;
            default:                  seq_d = SEQ_DIRECT;
        endcase
    end

    // register and comparator updates driven by the sequence state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= 1'b0;
            ien_q      <= 1'b0;
            per_q      <= 1'b0;
            f32_q      <= 1'b0;
            route_q    <= '0;
            cmp_q      <= '0;
            period_q   <= '0;
            stage_lo_q <= '0;
            armed_q    <= 1'b0;
        end else begin
            if (cfg_we) begin
                level_q <= wdata[B_LEVEL];
                ien_q   <= wdata[B_IEN];
                per_q   <= PCAP & wdata[B_PER];
                f32_q   <= wdata[B_F32];
                if (RCAP[route_wr]) route_q <= route_wr;
            end
            if (cmp_lo_we) stage_lo_q <= wdata;
            if (commit && seq_q == SEQ_PERIOD) period_q <= commit_val;
            if (commit && seq_q != SEQ_PERIOD) begin
                cmp_q   <= commit_val;
                armed_q <= 1'b1;
            end else if (match) begin
                if (per_q) cmp_q   <= next_cmp;
                else       armed_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rd                = '0;
        cfg_rd[B_LEVEL]       = level_q;
        cfg_rd[B_IEN]         = ien_q;
        cfg_rd[B_PER]         = per_q;
        cfg_rd[B_PCAP]        = PCAP;
        cfg_rd[B_F32]         = f32_q;
        cfg_rd[B_ROUTE +: RW] = route_q;
    end

    assign cmp_rd   = cmp_q;
    assign fire     = match;
    assign is_level = level_q;
    assign irq_en   = ien_q;
    assign route    = route_q;
endmodule

// File: rtl/evt_irq_route.sv
`timescale 1ns/1ps
module evt_irq_route #(
    parameter int  NUM_CH    = 3,
    parameter int  NUM_LINES = 4,
    localparam int RW        = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      fire,
    input  logic [NUM_CH-1:0]      level,
    input  logic [NUM_CH-1:0]      ien,
    input  logic [NUM_CH-1:0]      sts,
    input  logic [NUM_CH*RW-1:0]   route_flat,
    output logic [NUM_CH-1:0]      ch_irq,
    output logic [NUM_LINES-1:0]   irq_line
);
    logic [NUM_CH-1:0] pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= fire & ~level & ien;
    end

    assign ch_irq = (level & sts & ien) | (~level & pulse_q);

    always_comb begin
        irq_line = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            irq_line[route_flat[c*RW +: RW]] = irq_line[route_flat[c*RW +: RW]] | ch_irq[c];
        end
    end
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int                            NUM_CH    = 3,
    parameter int                            NUM_LINES = 4,
    parameter logic [DATA_W-1:0]             TICK_FS   = 32'd10_000_000,
    parameter logic [NUM_CH-1:0]             PER_CAP   = 3'b011,
    parameter logic [NUM_CH*NUM_LINES-1:0]   ROUTE_CAP = 12'hCF3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CH-1:0]    ch_irq,
    output logic [NUM_LINES-1:0] irq_line
);
    localparam int RW     = $clog2(NUM_LINES);
    localparam int SLOT_W = ADDR_W - CH_SLOT_LSB;

    logic                 gen_en_q;
    logic [NUM_CH-1:0]    sts_q, sts_clr;
    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_CH-1:0]    ch_hit, fire, level, ien;
    logic [NUM_CH*RW-1:0] route_flat;
    logic [DATA_W-1:0]    ch_cfg [NUM_CH];
    logic [CNT_W-1:0]     ch_cmp [NUM_CH];
    logic [DATA_W-1:0]    rd_next, cap_lo;

    assign cap_lo  = {18'b0, 1'b1, 5'(NUM_CH-1), CAP_REV};
    assign sts_clr = (bus_wr && bus_addr == A_STS) ? bus_wdata[NUM_CH-1:0] : '0;

    evt_main_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (gen_en_q),
        .wr_lo (bus_wr && bus_addr == A_CNT_LO),
        .wr_hi (bus_wr && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_hit[i] = (bus_addr[ADDR_W-1:CH_SLOT_LSB] == SLOT_W'(CH_BASE_IDX + i)) &&
                           !bus_addr[4] && (bus_addr[1:0] == 2'b00);

        evt_channel #(
            .PCAP      (PER_CAP[i]),
            .NUM_LINES (NUM_LINES),
            .RCAP      (ROUTE_CAP[i*NUM_LINES +: NUM_LINES])
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt_q),
            .cnt_en    (gen_en_q),
            .cfg_we    (bus_wr && ch_hit[i] && bus_addr[3:2] == R_CFG),
            .cmp_lo_we (bus_wr && ch_hit[i] && bus_addr[3:2] == R_CMPLO),
            .cmp_hi_we (bus_wr && ch_hit[i] && bus_addr[3:2] == R_CMPHI),
            .wdata     (bus_wdata),
            .cfg_rd    (ch_cfg[i]),
            .cmp_rd    (ch_cmp[i]),
            .fire      (fire[i]),
            .is_level  (level[i]),
            .irq_en    (ien[i]),
            .route     (route_flat[i*RW +: RW])
        );
    end

    evt_irq_route #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .level      (level),
        .ien        (ien),
        .sts        (sts_q),
        .route_flat (route_flat),
        .ch_irq     (ch_irq),
        .irq_line   (irq_line)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en_q <= 1'b0;
            sts_q    <= '0;
        end else begin
            if (bus_wr && bus_addr == A_GEN) gen_en_q <= bus_wdata[0];
            sts_q <= (sts_q & ~sts_clr) | (fire & level);
        end
    end

    always_comb begin
        rd_next = '0;
        if (bus_addr == A_CAP_LO)      rd_next = cap_lo;
        else if (bus_addr == A_CAP_HI) rd_next = TICK_FS;
        else if (bus_addr == A_GEN)    rd_next = {{(DATA_W-1){1'b0}}, gen_en_q};
        else if (bus_addr == A_STS)    rd_next = {{(DATA_W-NUM_CH){1'b0}}, sts_q};
        else if (bus_addr == A_CNT_LO) rd_next = cnt_q[DATA_W-1:0];
        else if (bus_addr == A_CNT_HI) rd_next = cnt_q[CNT_W-1:DATA_W];
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                case (bus_addr[3:2])
                    R_CFG:   rd_next = ch_cfg[i];
                    R_RCAP:  rd_next = {{(DATA_W-NUM_LINES){1'b0}}, ROUTE_CAP[i*NUM_LINES +: NUM_LINES]};
                    R_CMPLO: rd_next = ch_cmp[i][DATA_W-1:0];
                    default: rd_next = ch_cmp[i][CNT_W-1:DATA_W];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_CH-1:0]    sts_wdata,
    input logic [CNT_W-1:0]     cnt,
    input logic                 gen_en,
    input logic [NUM_CH-1:0]    sts,
    input logic [NUM_CH-1:0]    fire,
    input logic [NUM_CH-1:0]    level,
    input logic [NUM_CH-1:0]    ch_irq,
    input logic [NUM_LINES-1:0] irq_line
);
    logic              cnt_wr;
    logic [NUM_CH-1:0] clr;

    assign cnt_wr = bus_wr && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
    assign clr    = (bus_wr && bus_addr == A_STS) ? sts_wdata : '0;

    // R2: counter frozen while disabled
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !cnt_wr) |=> (cnt == $past(cnt)));

    // R2: counter steps by exactly one while enabled
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1));

    // R5: a level firing is recorded in status
    a_r5_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fire & level)) |=> ((sts & $past(fire & level)) == $past(fire & level)));

    // R5: a status bit drops only after a one is written to it
    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (|sts) |=> ((($past(sts) & ~$past(clr)) & ~sts) == '0));

    // R11: lines carry nothing beyond the channel interrupts
    a_r11_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_line) <= $countones(ch_irq));
endmodule

bind evt_timer evt_timer_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .sts_wdata (bus_wdata[NUM_CH-1:0]),
    .cnt       (cnt_q),
    .gen_en    (gen_en_q),
    .sts       (sts_q),
    .fire      (fire),
    .level     (level),
    .ch_irq    (ch_irq),
    .irq_line  (irq_line)
);

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
    localparam logic [9:0] CAP_LO = 10'h000, CAP_HI = 10'h004, GEN = 10'h010,
                           STS = 10'h020, CNT_LO = 10'h0F0, CNT_HI = 10'h0F4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ch_irq;
    logic [3:0]  irq_line;

    int unsigned cyc = 0;
    int unsigned t_en = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_irq(ch_irq), .irq_line(irq_line)
    );

    function automatic logic [9:0] ch_a(int ch, int ofs);
        return 10'(32'h100 + 32'h20 * ch + ofs);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_count();
        wr(GEN, 32'h1);
        t_en = cyc;
    endtask

    task automatic wait_cnt(int unsigned v);
        while ((cyc - t_en) < v) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {28'b0, ch_irq}, 32'h0);
        chk("R1 lines", {28'b0, irq_line}, 32'h0);
        rd(CAP_LO, d); chk("R1 cap lo", d, 32'h0000_2201);
        rd(CAP_HI, d); chk("R1 cap hi", d, 32'd10_000_000);
        rd(GEN, d);    chk("R1 gen", d, 32'h0);
        rd(STS, d);    chk("R1 sts", d, 32'h0);
        rd(CNT_LO, d); chk("R1 cnt", d, 32'h0);
        rd(ch_a(0, 0), d); chk("R1 ch0 cfg", d, 32'h10);
        rd(ch_a(2, 0), d); chk("R1 ch2 cfg", d, 32'h0);
        rd(ch_a(1, 4), d); chk("R1 ch1 rcap", d, 32'hF);
    endtask

    task automatic t_counter();
        logic [31:0] d;
        int unsigned c0;
        repeat (4) @(negedge clk);
        rd(CNT_LO, d); chk("R2 idle hold", d, 32'h0);
        wr(CNT_LO, 32'd100);
        wr(CNT_HI, 32'd7);
        rd(CNT_HI, d); chk("R2 hi write", d, 32'd7);
        start_count();
        wait_cnt(5);
        c0 = cyc;
        rd(CNT_LO, d); chk("R2 running", d, 32'd100 + (c0 - t_en));
        wait_cnt(10);
        c0 = cyc;
        wr(GEN, 32'h0);
        rd(CNT_LO, d); chk("R2 frozen", d, 32'd100 + (c0 - t_en) + 1);
        repeat (5) @(negedge clk);
        rd(CNT_LO, d); chk("R2 still frozen", d, 32'd100 + (c0 - t_en) + 1);
    endtask

    task automatic t_oneshot_level();
        logic [31:0] d;
        wr(ch_a(0, 0), 32'h6);
        wr(ch_a(0, 8), 32'd40);
        wr(ch_a(0, 12), 32'd0);
        start_count();
        wait_cnt(40); chk("R3 before match", {31'b0, ch_irq[0]}, 32'h0);
        wait_cnt(41); chk("R3 after match", {31'b0, ch_irq[0]}, 32'h1);
        chk("R11 line0", {28'b0, irq_line}, 32'h1);
        wait_cnt(60); chk("R5 level held", {31'b0, ch_irq[0]}, 32'h1);
        rd(STS, d);   chk("R5 status set", d, 32'h1);
        wr(STS, 32'h0);
        chk("R5 write0 no effect", {31'b0, ch_irq[0]}, 32'h1);
        wr(STS, 32'h1);
        chk("R5 write1 clears", {31'b0, ch_irq[0]}, 32'h0);
        wait_cnt(120); chk("R3 no refire", {31'b0, ch_irq[0]}, 32'h0);
        rd(STS, d);    chk("R3 status stays clear", d, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr(ch_a(1, 0), 32'h2);
        wr(ch_a(1, 8), 32'd30);
        wr(ch_a(1, 12), 32'd0);
        start_count();
        wait_cnt(35); chk("R10 gated", {31'b0, ch_irq[1]}, 32'h0);
        rd(STS, d);   chk("R10 status kept", d, 32'h2);
        wr(ch_a(1, 0), 32'h6);
        chk("R10 enable raises", {31'b0, ch_irq[1]}, 32'h1);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(ch_a(1, 0), 32'h404);
        wr(ch_a(1, 8), 32'd25);
        wr(ch_a(1, 12), 32'd0);
        start_count();
        wait_cnt(25); chk("R4 before", {31'b0, ch_irq[1]}, 32'h0);
        wait_cnt(26); chk("R4 pulse", {31'b0, ch_irq[1]}, 32'h1);
        chk("R11 line2", {28'b0, irq_line}, 32'h4);
        wait_cnt(27); chk("R4 pulse ends", {31'b0, ch_irq[1]}, 32'h0);
        rd(STS, d);   chk("R4 no status", d, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        wr(ch_a(0, 0), 32'h4C);
        rd(ch_a(0, 0), d); chk("R6 vset reads 0", d, 32'h1C);
        wr(ch_a(0, 8), 32'd20);
        wr(ch_a(0, 12), 32'd0);
        wr(ch_a(0, 8), 32'd15);
        wr(ch_a(0, 12), 32'd0);
        rd(ch_a(0, 8), d); chk("R6 first kept", d, 32'd20);
        start_count();
        for (int n = 0; n < 4; n++) begin
            wait_cnt(20 + 15 * n);
            chk("R7 low before", {31'b0, ch_irq[0]}, 32'h0);
            wait_cnt(21 + 15 * n);
            chk("R7 pulse", {31'b0, ch_irq[0]}, 32'h1);
        end
        rd(ch_a(0, 8), d); chk("R7 cmp advanced", d, 32'd80);
    endtask

    task automatic t_nocap();
        logic [31:0] d;
        wr(ch_a(2, 0), 32'h4E);
        rd(ch_a(2, 0), d); chk("R8 bits dropped", d, 32'h6);
        wr(ch_a(2, 8), 32'd10);
        wr(ch_a(2, 12), 32'd0);
        wr(ch_a(2, 8), 32'd5);
        wr(ch_a(2, 12), 32'd0);
        rd(ch_a(2, 8), d); chk("R8 direct commit", d, 32'd5);
        start_count();
        wait_cnt(6); chk("R8 fires", {31'b0, ch_irq[2]}, 32'h1);
        wr(STS, 32'h4);
        wait_cnt(30); chk("R8 one-shot", {31'b0, ch_irq[2]}, 32'h0);
    endtask

    task automatic t_force32();
        logic [31:0] d;
        wr(CNT_HI, 32'd3);
        wr(ch_a(0, 0), 32'h106);
        wr(ch_a(0, 12), 32'hAB);
        wr(ch_a(0, 8), 32'd12);
        rd(ch_a(0, 12), d); chk("R9 hi cleared", d, 32'h0);
        start_count();
        wait_cnt(12); chk("R9 before", {31'b0, ch_irq[0]}, 32'h0);
        wait_cnt(13); chk("R9 low-32 match", {31'b0, ch_irq[0]}, 32'h1);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(ch_a(0, 0), 32'h606);
        rd(ch_a(0, 0), d); chk("R11 bad route ignored", d, 32'h16);
        wr(ch_a(0, 0), 32'h206);
        rd(ch_a(0, 0), d); chk("R11 route accepted", d, 32'h216);
        wr(ch_a(0, 8), 32'd8);
        wr(ch_a(0, 12), 32'd0);
        start_count();
        wait_cnt(9); chk("R11 line1", {28'b0, irq_line}, 32'h2);
    endtask

    initial begin
        do_reset(); t_reset();
        do_reset(); t_counter();
        do_reset(); t_oneshot_level();
        do_reset(); t_gate();
        do_reset(); t_edge();
        do_reset(); t_periodic();
        do_reset(); t_nocap();
        do_reset(); t_force32();
        do_reset(); t_route();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule